// File: doc/BRIEF.md
# Q15 Fractional Multiply-Accumulate Unit

This block is a two-stage pipelined datapath for signed fractional arithmetic on 16-bit Q15 operands. Each accepted operation multiplies two operands and produces either a plain product or a sum with an addend. The sum is 32 bits wide in narrow mode and 64 bits wide in wide mode. Per operation, mode inputs select several options:

- a one-bit left-justify of the narrow product (1.31 instead of 2.30);
- rounding to the upper 16 bits;
- a packed half-word result;
- clamping of overflowing results.

Two sticky flags record overflows and near-overflows across many operations. A filter loop can read them, and so can an FFT pass that needs to decide on block scaling. Software clears the flags with a strobe. The left-justified product of -1.0 by -1.0 cannot be represented. It is replaced by the largest positive value, and this replacement does not disturb either flag.

Top module: `q15_mac`

## Requirements
- R1: An operation accepted with `in_valid` high at a rising edge appears on `result` with `out_valid` high after the second rising edge. `out_valid` is low in every cycle that does not follow such an operation by two edges.
- R2: In narrow mode (`wide_en`=0) with `acc_en`=0, `result` is the signed 32-bit product of `op_a` and `op_b`, sign-extended to 64 bits. With `lj_en`=1 the product is doubled (1.31 form); with `lj_en`=0 it is left as is (2.30 form, one guard bit).
- R3: In narrow mode with `lj_en`=1 and both operands 0x8000, the product is 0x7FFFFFFF. A plain multiply (`acc_en`=0) with this product never sets `ovf_flag` or `aov_flag`.
- R4: In narrow mode with `acc_en`=1, the product is added to the sign-extended `addend[31:0]`. With `acc_en`=0 the addend has no effect on `result`.
- R5: In wide mode (`wide_en`=1) the unshifted product is shifted left by 16 bits (18.46 form). With `acc_en`=1 it is then added to the full 64-bit `addend`. `lj_en`, `rnd_en` and `half_en` have no effect in wide mode.
- R6: In narrow mode, `rnd_en`=1 adds 0x8000 to the 32-bit sum. With `half_en`=0, bits 15:0 of the result are then zero. With `half_en`=1, `result` is the sign-extended upper 16 bits of the 32-bit value.
- R7: An overflow is a true sum outside the signed 32-bit range in narrow mode, or outside the signed 64-bit range in wide mode. With `sat_en`=1, an overflowing result is clamped to the most positive or most negative value of that width, before the low bits are cleared by rounding. With `sat_en`=0, the result wraps.
- R8: `aov_flag` is set by any operation that overflows. It is also set when the top two bits of the wrapped 32-bit or 64-bit sum differ. `ovf_flag` is set by any operation that overflows.
- R9: Both flags stay set until `flag_clr` is high at a rising edge. If that edge also completes an operation that sets a flag, the flag ends up set.
- R10: While `rst_n` is low, `out_valid`, `result`, `ovf_flag` and `aov_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| op_a | input | 16 | Q15 operand A |
| op_b | input | 16 | Q15 operand B |
| addend | input | 64 | Addend (low 32 bits used in narrow mode) |
| acc_en | input | 1 | Add the addend to the product |
| wide_en | input | 1 | 64-bit accumulation mode |
| lj_en | input | 1 | Left-justify the narrow product by one bit |
| rnd_en | input | 1 | Round to upper 16 bits (narrow mode) |
| half_en | input | 1 | Packed half-word result when rounding |
| sat_en | input | 1 | Clamp overflowing results |
| flag_clr | input | 1 | Clear both sticky flags |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Result, sign-extended from 32 bits in narrow mode |
| ovf_flag | output | 1 | Sticky overflow flag |
| aov_flag | output | 1 | Sticky advance-overflow flag |

## Verification
The bench uses the default parameters: 16-bit operands, a 32-bit narrow sum, a 64-bit wide sum and a 16-bit wide shift. With these values it sweeps eight corner operands (including both extremes, -1 LSB and one half) against each other under all 64 combinations of the six mode bits. Addends are rotated so that both wrap directions, the -1 × -1 replacement with and without accumulation, and rounding into saturation are all reached. The clear strobe is toggled so that clear-only and clear-with-set edges both occur against a sticky-flag model kept in the bench.

// File: rtl/q15_mac_pkg.sv
package q15_mac_pkg;
  typedef struct packed {
    logic acc;
    logic wide;
    logic lj;
    logic rnd;
    logic half;
    logic sat;
  } mac_mode_t;
endpackage

// File: rtl/q15_mac_mul.sv
// Stage 1: signed product, left-justify and -1 x -1 replacement.
module q15_mac_mul
  import q15_mac_pkg::*;
#(
  parameter int OPW = 16,
  parameter int WW  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPW-1:0]    op_a,
  input  logic [OPW-1:0]    op_b,
  input  logic [WW-1:0]     addend,
  input  mac_mode_t         mode,
  output logic              s1_valid,
  output logic [2*OPW-1:0]  s1_prod,
  output logic              s1_forced,
  output mac_mode_t         s1_mode,
  output logic [WW-1:0]     s1_addend
);
  localparam int NW = 2 * OPW;
  localparam logic [OPW-1:0] OP_MIN = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [NW-1:0]  N_MAX  = {1'b0, {(NW-1){1'b1}}};

  logic [NW-1:0] raw_prod;
  logic [NW-1:0] prod_d;
  logic          forced_d;

  always_comb begin
    raw_prod = $signed(op_a) * $signed(op_b);
    forced_d = mode.lj && !mode.wide && (op_a == OP_MIN) && (op_b == OP_MIN);
    if (mode.wide)     prod_d = raw_prod;
    else if (forced_d) prod_d = N_MAX;
    else if (mode.lj)  prod_d = raw_prod << 1;
    else               prod_d = raw_prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_prod   <= '0;
      s1_forced <= 1'b0;
      s1_mode   <= '0;
      s1_addend <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod   <= prod_d;
        s1_forced <= forced_d;
        s1_mode   <= mode;
        s1_addend <= addend;
      end
    end
  end
endmodule

// File: rtl/q15_mac_acc.sv
// Stage 2 combinational part: add, round, saturate, detect flags.
module q15_mac_acc
  import q15_mac_pkg::*;
#(
  parameter int OPW = 16,
  parameter int WW  = 64,
  parameter int WSH = 16
) (
  input  logic [2*OPW-1:0] prod,
  input  logic             forced,
  input  mac_mode_t        mode,
  input  logic [WW-1:0]    addend,
  output logic [WW-1:0]    res,
  output logic             ovf,
  output logic             aov
);
  localparam int NW = 2 * OPW;
  localparam logic [NW-1:0] N_MAX = {1'b0, {(NW-1){1'b1}}};
  localparam logic [NW-1:0] N_MIN = {1'b1, {(NW-1){1'b0}}};
  localparam logic [WW-1:0] W_MAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic [WW-1:0] W_MIN = {1'b1, {(WW-1){1'b0}}};
  localparam logic [NW+1:0] RND_K = (NW+2)'(1) << (OPW - 1);

  logic [NW+1:0] sum_n;
  logic [NW-1:0] wrap_n, sat_n, shaped_n;
  logic          ovf_n, aov_n;
  logic [WW:0]   prod_w, sum_w;
  logic [WW-1:0] sat_w;
  logic          ovf_w, aov_w;

  always_comb begin
    // narrow path
    sum_n = {{2{prod[NW-1]}}, prod}
          + (mode.acc ? {{2{addend[NW-1]}}, addend[NW-1:0]} : '0)
          + (mode.rnd ? RND_K : '0);
    wrap_n = sum_n[NW-1:0];
    ovf_n  = !((sum_n[NW+1] == sum_n[NW]) && (sum_n[NW] == sum_n[NW-1]));
    aov_n  = ovf_n | (wrap_n[NW-1] ^ wrap_n[NW-2]);
    sat_n  = (mode.sat && ovf_n) ? (sum_n[NW+1] ? N_MIN : N_MAX) : wrap_n;
    if (!mode.rnd)      shaped_n = sat_n;
    else if (mode.half) shaped_n = {{OPW{sat_n[NW-1]}}, sat_n[NW-1:OPW]};
    else                shaped_n = {sat_n[NW-1:OPW], {OPW{1'b0}}};

    // wide path
    prod_w = {{(WW+1-NW){prod[NW-1]}}, prod} << WSH;
    sum_w  = prod_w + (mode.acc ? {addend[WW-1], addend} : '0);
    ovf_w  = sum_w[WW] ^ sum_w[WW-1];
    aov_w  = ovf_w | (sum_w[WW-1] ^ sum_w[WW-2]);
    sat_w  = (mode.sat && ovf_w) ? (sum_w[WW] ? W_MIN : W_MAX) : sum_w[WW-1:0];

    if (mode.wide) begin
      res = sat_w;
      ovf = ovf_w;
      aov = aov_w;
    end else begin
      res = {{(WW-NW){shaped_n[NW-1]}}, shaped_n};
      ovf = ovf_n;
      aov = aov_n;
    end
    if (forced && !mode.acc) begin
      ovf = 1'b0;
      aov = 1'b0;
    end
  end
endmodule

// File: rtl/q15_mac_flags.sv
// Sticky flags, set wins over clear.
module q15_mac_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic ovf_set,
  input  logic aov_set,
  input  logic clr,
  output logic ovf_q,
  output logic aov_q
);
  logic ovf_d, aov_d;

  always_comb begin
    ovf_d = (set_en && ovf_set) || (ovf_q && !clr);
    aov_d = (set_en && aov_set) || (aov_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      aov_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      aov_q <= aov_d;
    end
  end
endmodule

// File: rtl/q15_mac.sv
module q15_mac
  import q15_mac_pkg::*;
#(
  parameter int OPW = 16,
  parameter int WW  = 64,
  parameter int WSH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  logic [WW-1:0]  addend,
  input  logic           acc_en,
  input  logic           wide_en,
  input  logic           lj_en,
  input  logic           rnd_en,
  input  logic           half_en,
  input  logic           sat_en,
  input  logic           flag_clr,
  output logic           out_valid,
  output logic [WW-1:0]  result,
  output logic           ovf_flag,
  output logic           aov_flag
);
  localparam int NW = 2 * OPW;

  mac_mode_t     in_mode;
  logic          s1_valid;
  logic [NW-1:0] s1_prod;
  logic          s1_forced;
  mac_mode_t     s1_mode;
  logic [WW-1:0] s1_addend;
  logic [WW-1:0] s2_res;
  logic          s2_ovf, s2_aov;
  logic [WW-1:0] result_d;

  always_comb begin
    in_mode.acc  = acc_en;
    in_mode.wide = wide_en;
    in_mode.lj   = lj_en;
    in_mode.rnd  = rnd_en;
    in_mode.half = half_en;
    in_mode.sat  = sat_en;
  end

  q15_mac_mul #(.OPW(OPW), .WW(WW)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .addend(addend), .mode(in_mode),
    .s1_valid(s1_valid), .s1_prod(s1_prod), .s1_forced(s1_forced),
    .s1_mode(s1_mode), .s1_addend(s1_addend)
  );

  q15_mac_acc #(.OPW(OPW), .WW(WW), .WSH(WSH)) u_acc (
    .prod(s1_prod), .forced(s1_forced), .mode(s1_mode), .addend(s1_addend),
    .res(s2_res), .ovf(s2_ovf), .aov(s2_aov)
  );

  q15_mac_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(s1_valid),
    .ovf_set(s2_ovf), .aov_set(s2_aov), .clr(flag_clr),
    .ovf_q(ovf_flag), .aov_q(aov_flag)
  );

  always_comb begin
    result_d = s1_valid ? s2_res : result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_valid;
      result    <= result_d;
    end
  end
endmodule

// File: rtl/q15_mac_chk.sv
module q15_mac_chk (
  input logic clk,
  input logic rst_n,
  input logic flag_clr,
  input logic out_valid,
  input logic ovf_flag,
  input logic aov_flag,
  input logic s1_valid,
  input logic s1_forced,
  input logic s1_acc
);
  // R1: output valid follows the stage-1 valid by one edge
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));

  // R3: a forced plain multiply leaves clear flags clear
  a_r3_forced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_forced && !s1_acc && !ovf_flag && !aov_flag)
      |=> (!ovf_flag && !aov_flag));

  // R8: overflow always comes with advance overflow
  a_r8_ovf_implies_aov: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> aov_flag);

  // R9: a flag only rises when an operation completes
  a_r9_rise_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) || $rose(aov_flag)) |-> out_valid);

  // R9: flags hold without a clear
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && ovf_flag && aov_flag) |=> (ovf_flag && aov_flag));

  // R9: clear with no completing operation empties both flags
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !s1_valid) |=> (!ovf_flag && !aov_flag));
endmodule

bind q15_mac q15_mac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .out_valid(out_valid),
  .ovf_flag(ovf_flag), .aov_flag(aov_flag), .s1_valid(s1_valid),
  .s1_forced(s1_forced), .s1_acc(s1_mode.acc)
);

// File: tb/q15_mac_tb.sv
`timescale 1ns/1ps
module q15_mac_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, acc_en, wide_en, lj_en, rnd_en, half_en, sat_en, flag_clr;
  logic [15:0] op_a, op_b;
  logic [63:0] addend;
  logic        out_valid, ovf_flag, aov_flag;
  logic [63:0] result;

  int n_chk = 0;
  int n_err = 0;
  logic exp_ovf = 1'b0;
  logic exp_aov = 1'b0;

  always #5 clk = ~clk;

  q15_mac u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .addend(addend), .acc_en(acc_en), .wide_en(wide_en), .lj_en(lj_en),
    .rnd_en(rnd_en), .half_en(half_en), .sat_en(sat_en), .flag_clr(flag_clr),
    .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag), .aov_flag(aov_flag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [63:0] add,
                       input logic [5:0] m, output logic [63:0] r,
                       output logic ov, output logic av);
    logic acc, wide, lj, rnd, half, sat, forced;
    longint p, pj, s;
    logic [31:0] w, rs;
    logic signed [65:0] s66;
    {acc, wide, lj, rnd, half, sat} = m;
    p = longint'($signed(a)) * longint'($signed(b));
    forced = 1'b0;
    if (!wide) begin
      if (lj && a == 16'h8000 && b == 16'h8000) begin
        pj = 64'sd2147483647; forced = 1'b1;      // R3
      end else pj = lj ? p * 2 : p;               // R2
      s = pj + (acc ? longint'($signed(add[31:0])) : 64'sd0) + (rnd ? 64'sd32768 : 64'sd0);
      ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      w  = s[31:0];
      av = ov || (w[31] != w[30]);
      rs = (sat && ov) ? ((s < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF) : w;
      if (rnd) rs = half ? {{16{rs[31]}}, rs[31:16]} : {rs[31:16], 16'h0000};
      r = {{32{rs[31]}}, rs};
      if (forced && !acc) begin ov = 1'b0; av = 1'b0; end
    end else begin
      s66 = 66'(p) * 66'sd65536 + (acc ? 66'($signed(add)) : 66'sd0);  // R5
      ov = !((s66[65] == s66[64]) && (s66[64] == s66[63]));
      r  = (sat && ov) ? (s66[65] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF)
                       : s66[63:0];
      av = ov || (s66[63] != s66[62]);
    end
  endtask

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic [63:0] add,
                        input logic [5:0] m, input logic clr);
    logic [63:0] er;
    logic eo, ea;
    model(a, b, add, m, er, eo, ea);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; addend = add;
    {acc_en, wide_en, lj_en, rnd_en, half_en, sat_en} = m;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = clr;
    @(negedge clk);
    flag_clr = 1'b0;
    exp_ovf = eo | (exp_ovf & ~clr);
    exp_aov = ea | (exp_aov & ~clr);
    check("R1 valid", {63'd0, out_valid}, 64'd1);
    check("R2-R7 result", result, er);
    check("R8/R9 flags", {62'd0, ovf_flag, aov_flag}, {62'd0, exp_ovf, exp_aov});
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] ops [8];
    logic [63:0] adds [4];
    ops = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001, 16'h4000, 16'h7FFF, 16'hC000};
    adds = '{64'h0, 64'h0000_0000_7FFF_0000, 64'hFFFF_FFFF_8000_0000, 64'h7FFF_FFFF_FFFF_0000};
    rst_n = 1'b0; in_valid = 1'b0; flag_clr = 1'b0; op_a = '0; op_b = '0; addend = '0;
    acc_en = 0; wide_en = 0; lj_en = 0; rnd_en = 0; half_en = 0; sat_en = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", {result[61:0], out_valid, ovf_flag}, 64'd0);
    check("R10 reset aov", {63'd0, aov_flag}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {63'd0, out_valid}, 64'd0);
    // R3: forced product, plain multiply, flags clean
    run_op(16'h8000, 16'h8000, 64'h0, 6'b001000, 1'b0);
    check("R3 forced", result, 64'h0000_0000_7FFF_FFFF);
    // R4/R6/R7/R8/R9 sweep over corners and all modes
    for (int mi = 0; mi < 64; mi++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(ops[i], ops[j], adds[(i + j + mi) % 4], 6'(mi), ((i + mi) % 3) == 0);
    // R9: clear alone, then check flags empty and out_valid low
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R9 clear", {62'd0, ovf_flag, aov_flag}, 64'd0);
    check("R1 low after", {63'd0, out_valid}, 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule